// File: doc/BRIEF.md
# Mask-Driven Vector Compress/Expand Unit

This block rearranges the elements of one vector under a per-element mask. It holds one mask bit for each element. In compress mode it gathers the elements whose mask bit is set and packs them into the lowest result positions, in ascending order and with no gaps. In expand mode it does the reverse. It takes elements one after another from the start of a packed source and drops each one at the position of the next set mask bit. Every position that receives no element keeps the value of a background vector.

A request is made by presenting the operation, the vector length, the mask, the source vector and the background vector together with a one-cycle start pulse. These controls are plain level and pulse pins, with no valid/ready handshake, because the unit has no stream interface. At start the result register is loaded from the background vector. The unit then examines one element per cycle, using a scan index and a single packed-side pointer. When the scan finishes it raises a one-cycle done pulse. From that pulse until the next accepted start, the result and the packed length (the mask population count over the active length) stay stable. A start that arrives while the unit is busy is dropped. There is no queue, so the caller must wait for done before it starts the next request.

Top module: `cmx_unit`

## Requirements
- R1: With op_i = 0 (compress), the source elements whose mask bit is set appear in result positions 0, 1, 2, ... in ascending source order with no gaps. Element i of any vector port occupies bits [i*EW +: EW].
- R2: At done, count_o equals the number of set mask bits among elements 0 to vl-1. This holds for both operations.
- R3: In compress, result positions at and above count_o hold the background vector's element at the same position.
- R4: With op_i = 1 (expand), the k-th source element (k counted from 0) lands at the position of the k-th set mask bit.
- R5: In expand, every position whose mask bit is clear, or that lies at or beyond vl, holds the background element at that position. An all-zero mask therefore returns the background vector unchanged.
- R6: Mask bits at or beyond vl have no effect. A vl greater than NELEM is treated as NELEM.
- R7: done_o is high for exactly one cycle. It rises min(vl, NELEM) cycles after the clock edge that accepted start, and for vl = 0 it rises in the cycle right after that edge. busy_o is high from the accepting edge through the done cycle.
- R8: A start pulse while busy_o is high is ignored. The running request completes with its own inputs.
- R9: After reset, done_o and busy_o are low, count_o is 0 and result_o is all zeros.
- R10: After done, result_o and count_o stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse, taken only when idle |
| op_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | LW | Active vector length, clamped to NELEM |
| mask_i | input | NELEM | One bit per element |
| src_i | input | NELEM*EW | Source vector (packed source in expand) |
| bg_i | input | NELEM*EW | Background vector, initial result contents |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | LW | Packed length (mask population count) |
| result_o | output | NELEM*EW | Result vector |

## Verification
The bench targets several corner cases and the wrong behaviour each one exposes:
- A sparse mask. A design that indexed the packed side by the scan index would leave gaps in compress, or take the wrong source element in expand.
- A vector length shorter than the mask's set bits. A design that scanned the whole mask would report too large a count and write past the active length.
- A length above the element count, and a length of zero. These catch a missing clamp, and an off-by-one in the done timing.
- A second start issued mid-run. A design that accepted it would corrupt the result of the first request.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  typedef enum logic {
    OP_COMPRESS = 1'b0,
    OP_EXPAND   = 1'b1
  } cmx_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cmx_state_e;
endpackage

// File: rtl/cmx_elem_pick.sv
module cmx_elem_pick #(
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int IW   = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic [NELEM*EW-1:0] vec_i,
  input  logic [IW-1:0]       sel_i,
  output logic [EW-1:0]       elem_o
);
  logic [EW-1:0] lanes [NELEM];

  for (genvar g = 0; g < NELEM; g++) begin : g_lane
    assign lanes[g] = vec_i[g*EW +: EW];
  end

  assign elem_o = lanes[sel_i];
endmodule

// File: rtl/cmx_ctrl.sv
module cmx_ctrl
  import cmx_pkg::*;
#(
  parameter int NELEM = 8,
  localparam int LW   = $clog2(NELEM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] vl_i,
  output logic          load_o,
  output logic          step_o,
  output logic [LW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [LW-1:0] VL_MAX = LW'(NELEM);

  cmx_state_e    state_q;
  logic [LW-1:0] vl_q;
  logic [LW-1:0] idx_q;
  logic [LW-1:0] vl_clamped;
  logic          last_elem;

  assign vl_clamped = (vl_i > VL_MAX) ? VL_MAX : vl_i;
  assign last_elem  = (idx_q + LW'(1)) == vl_q;
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign step_o     = (state_q == ST_RUN);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign idx_o      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vl_q    <= vl_clamped;
          idx_q   <= '0;
          state_q <= (vl_clamped == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (last_elem) state_q <= ST_FIN;
          else           idx_q   <= idx_q + LW'(1);
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: completion pulse never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: busy stays up until the done cycle
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R6: scan never passes the clamped length
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> ((idx_q < vl_q) && (vl_q <= VL_MAX)));
endmodule

// File: rtl/cmx_dpath.sv
module cmx_dpath
  import cmx_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int LW   = $clog2(NELEM + 1),
  localparam int IW   = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int VW   = NELEM * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [LW-1:0] idx_i,
  input  logic          op_i,
  input  logic [NELEM-1:0] mask_i,
  input  logic [VW-1:0] src_i,
  input  logic [VW-1:0] bg_i,
  output logic [LW-1:0] count_o,
  output logic [VW-1:0] result_o
);
  cmx_op_e          op_q;
  logic [NELEM-1:0] mask_q;
  logic [VW-1:0]    src_q;
  logic [LW-1:0]    ptr_q;
  logic [EW-1:0]    res_q [NELEM];

  logic [IW-1:0] scan_sel;
  logic [IW-1:0] pack_sel;
  logic [IW-1:0] rd_sel;
  logic [IW-1:0] wr_sel;
  logic          hit;
  logic          wr_en;
  logic [EW-1:0] rd_elem;

  assign scan_sel = idx_i[IW-1:0];
  assign pack_sel = ptr_q[IW-1:0];
  assign hit      = mask_q[scan_sel];
  assign wr_en    = step_i && hit;
  // compress: read at scan position, write at packed pointer; expand: swapped
  assign rd_sel   = (op_q == OP_EXPAND) ? pack_sel : scan_sel;
  assign wr_sel   = (op_q == OP_EXPAND) ? scan_sel : pack_sel;

  cmx_elem_pick #(.NELEM(NELEM), .EW(EW)) u_pick (
    .vec_i  (src_q),
    .sel_i  (rd_sel),
    .elem_o (rd_elem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_COMPRESS;
      mask_q <= '0;
      src_q  <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      op_q   <= cmx_op_e'(op_i);
      mask_q <= mask_i;
      src_q  <= src_i;
      ptr_q  <= '0;
    end else if (wr_en) begin
      ptr_q  <= ptr_q + LW'(1);
    end
  end

  for (genvar g = 0; g < NELEM; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         res_q[g] <= '0;
      else if (load_i)                    res_q[g] <= bg_i[g*EW +: EW];
      else if (wr_en && wr_sel == IW'(g)) res_q[g] <= rd_elem;
    end
    assign result_o[g*EW +: EW] = res_q[g];
  end

  assign count_o = ptr_q;

  // R2: packed pointer can never run ahead of the scan index
  a_r2_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (ptr_q <= idx_i));
endmodule

// File: rtl/cmx_unit.sv
module cmx_unit
  import cmx_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int LW   = $clog2(NELEM + 1),
  localparam int VW   = NELEM * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [LW-1:0]    vl_i,
  input  logic [NELEM-1:0] mask_i,
  input  logic [VW-1:0]    src_i,
  input  logic [VW-1:0]    bg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LW-1:0]    count_o,
  output logic [VW-1:0]    result_o
);
  logic          load;
  logic          step;
  logic [LW-1:0] idx;

  cmx_ctrl #(.NELEM(NELEM)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .vl_i    (vl_i),
    .load_o  (load),
    .step_o  (step),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  cmx_dpath #(.NELEM(NELEM), .EW(EW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .idx_i    (idx),
    .op_i     (op_i),
    .mask_i   (mask_i),
    .src_i    (src_i),
    .bg_i     (bg_i),
    .count_o  (count_o),
    .result_o (result_o)
  );

  // R10: an idle unit without a start keeps its outputs
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(count_o)));

  // R8: a start while busy does not restart the scan
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/cmx_unit_tb_top.sv
`timescale 1ns/1ps
module cmx_unit_tb_top;
  localparam int NELEM = 8;
  localparam int EW    = 8;
  localparam int LW    = 4;
  localparam int VW    = 64;

  typedef struct packed {
    logic       op;
    logic [3:0] vl;
    logic [7:0] mask;
    logic [3:0] cnt;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 4'd8,  8'hB2, 4'd4},
    '{1'b1, 4'd8,  8'hB2, 4'd4},
    '{1'b0, 4'd8,  8'hFF, 4'd8},
    '{1'b1, 4'd5,  8'hFF, 4'd5},
    '{1'b0, 4'd4,  8'hF0, 4'd0},
    '{1'b1, 4'd8,  8'h00, 4'd0},
    '{1'b0, 4'd15, 8'h81, 4'd2},
    '{1'b1, 4'd3,  8'h05, 4'd2}
  };

  localparam logic [VW-1:0] SRC = 64'h8877665544332211;
  localparam logic [VW-1:0] BG  = 64'hF8F7F6F5F4F3F2F1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             op_i = 1'b0;
  logic [LW-1:0]    vl_i = '0;
  logic [NELEM-1:0] mask_i = '0;
  logic [VW-1:0]    src_i = '0;
  logic [VW-1:0]    bg_i = '0;
  logic             busy_o, done_o;
  logic [LW-1:0]    count_o;
  logic [VW-1:0]    result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cmx_unit #(.NELEM(NELEM), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .vl_i(vl_i),
    .mask_i(mask_i), .src_i(src_i), .bg_i(bg_i), .busy_o(busy_o),
    .done_o(done_o), .count_o(count_o), .result_o(result_o)
  );

  function automatic logic [VW-1:0] model(input logic op, input int vl,
      input logic [7:0] m, input logic [VW-1:0] s, input logic [VW-1:0] b);
    logic [VW-1:0] r = b;
    int k = 0;
    int len = (vl > NELEM) ? NELEM : vl;
    for (int i = 0; i < len; i++) begin
      if (m[i]) begin
        if (!op) r[k*EW +: EW] = s[i*EW +: EW];
        else     r[i*EW +: EW] = s[k*EW +: EW];
        k++;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start a request, wait for done; waits = negedges seen after the accepting edge
  task automatic run_op(input logic op, input logic [3:0] vl, input logic [7:0] m,
      input logic [VW-1:0] s, input logic [VW-1:0] b, output int waits);
    @(negedge clk);
    op_i = op; vl_i = vl; mask_i = m; src_i = s; bg_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waits = 0;
    while (!done_o && waits < 100) begin
      @(negedge clk);
      waits++;
    end
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
    $finish;
  end

  initial begin
    int w;
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", {63'd0, busy_o}, 64'd0);
    chk("R9 done", {63'd0, done_o}, 64'd0);
    chk("R9 count", {60'd0, count_o}, 64'd0);
    chk("R9 result", result_o, 64'd0);
    rst_n = 1'b1;

    // table walk: R1 R3 compress, R4 R5 expand, R2 count, R6 length, R7 timing
    for (int t = 0; t < 8; t++) begin
      run_op(TBL[t].op, TBL[t].vl, TBL[t].mask, SRC, BG, w);
      chk(TBL[t].op ? "R4 R5 R6 expand result" : "R1 R3 R6 compress result",
          result_o, model(TBL[t].op, int'(TBL[t].vl), TBL[t].mask, SRC, BG));
      chk("R2 count", {60'd0, count_o}, {60'd0, TBL[t].cnt});
      chk("R7 latency", 64'(w), 64'((TBL[t].vl > 8) ? 8 : TBL[t].vl));
      chk("R7 busy at done", {63'd0, busy_o}, 64'd1);
      @(negedge clk);
      chk("R7 done single", {63'd0, done_o}, 64'd0);
    end

    // R1 R3 explicit values: mask B2 packs elems 1,4,5,7
    run_op(1'b0, 4'd8, 8'hB2, SRC, BG, w);
    chk("R1 R3 compress literal", result_o, 64'hF8F7F6F588665522);
    // R4 R5 explicit values
    run_op(1'b1, 4'd8, 8'hB2, SRC, BG, w);
    chk("R4 R5 expand literal", result_o, 64'h44F73322F4F311F1);

    // R7 vl = 0: done in the cycle right after accept, result is background
    run_op(1'b1, 4'd0, 8'hFF, SRC, BG, w);
    chk("R7 zero length latency", 64'(w), 64'd0);
    chk("R5 zero length result", result_o, BG);
    chk("R2 zero length count", {60'd0, count_o}, 64'd0);

    // R10: outputs held after done
    held = result_o;
    repeat (4) @(negedge clk);
    chk("R10 result held", result_o, held);
    chk("R10 count held", {60'd0, count_o}, 64'd0);

    // R8: second start mid-run is ignored
    @(negedge clk);
    op_i = 1'b0; vl_i = 4'd8; mask_i = 8'hFF; src_i = SRC; bg_i = BG; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    op_i = 1'b1; mask_i = 8'h00; src_i = 64'h0; bg_i = 64'h0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    w = 0;
    while (!done_o && w < 100) begin
      @(negedge clk);
      w++;
    end
    chk("R8 result of first request", result_o, SRC);
    chk("R8 count of first request", {60'd0, count_o}, 64'd8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule